// File: doc/BRIEF.md
# Command-Fetching I/O Transfer Engine

The engine takes device transfers off the main processor's hands. The processor points the engine at a command block in shared memory and pulses a start input. From there the engine works on its own. It reads the command words over the memory port. It checks the operation. It then moves the requested number of words between the chosen device and memory, one word at a time. Every memory access waits for the arbiter's grant, so the engine only uses memory cycles that the arbiter hands over.

A command block is four consecutive memory words, and the engine reads them in this order: control word, data address, word count, flags. When the flags request chaining, the engine fetches the next block from the four words right after the current one. One interrupt pulse marks the end of the whole chain. An unknown operation ends the run with an error flag. A zero count ends the command without any transfer.

Top module: `cmd_iop`

## Requirements
- R1: After reset `busy`, `irq`, `err`, `mem_req`, `dev_rd` and `dev_wr` are all low. While `busy` is low, no memory or device access is made.
- R2: A `start` pulse while idle makes the engine read the four command words at `cmd_ptr`, `cmd_ptr+1`, `cmd_ptr+2`, `cmd_ptr+3` in that order. These are memory reads (`mem_we` low).
- R3: The control word carries the opcode in bits [3:0] and the device number in bits [7:4]. The device number appears on `dev_id` for the command's transfers and stays there after it. The data address is in the low address bits of word 1. The count is in the low 16 bits of word 2.
- R4: Opcode 1 (device to memory) makes the engine take `count` words from the device, each with a one-cycle `dev_rd` strobe. It writes them to consecutive memory words, starting at the data address.
- R5: Opcode 2 (memory to device) makes the engine read `count` consecutive memory words from the data address. It hands each word to the device with a one-cycle `dev_wr` strobe.
- R6: A memory access completes only in a cycle with `mem_gnt` high. Until then, `mem_req`, `mem_addr`, `mem_we` and the write data hold steady. Data moves correctly under any grant pattern.
- R7: When a run finishes, `irq` is high for exactly one cycle and `busy` falls in the next cycle. With `mem_gnt` held high, `irq` is high in the (6+2N)-th cycle counted from the edge that samples `start`, where N is the count.
- R8: Any opcode other than 1 or 2 ends the run with `err` high when `irq` pulses, 6 cycles after start. No memory write and no device strobe happen.
- R9: A count of zero ends the command with no memory write and no device strobe. With no chaining, `irq` comes 6 cycles after start and `err` is low.
- R10: Bit 0 of the flags word requests chaining. The next command is then fetched from the command address plus 4. Only one `irq` pulse is raised, after the last command of the chain.
- R11: A `start` pulse while `busy` is high is ignored. The running command completes unchanged and no second run follows.
- R12: `err` stays as set until the next accepted `start`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the command block at `cmd_ptr` |
| cmd_ptr | input | AW (16) | Word address of the first command block |
| busy | output | 1 | Engine is running a command or chain |
| irq | output | 1 | One-cycle completion interrupt |
| err | output | 1 | Last run ended on an unknown opcode |
| mem_req | output | 1 | Memory access request, held until granted |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW (16) | Memory word address |
| mem_wdata | output | DW (32) | Memory write data |
| mem_gnt | input | 1 | Arbiter grant; the access completes in this cycle |
| mem_rdata | input | DW (32) | Read data, valid in the granted cycle |
| dev_id | output | DEVW (4) | Device number of the current command |
| dev_rd | output | 1 | Take one word from the device |
| dev_rdata | input | DW (32) | Device word, valid while `dev_rd` is high |
| dev_wr | output | 1 | Hand one word to the device |
| dev_wdata | output | DW (32) | Word for the device |

## Verification
With the grant held high, the latency is fixed. The four fetch cycles, one decode cycle and two cycles per word give an `irq` in cycle 6+2N after the start edge. A chain adds 5+2N cycles for each further command, so a two-command chain with counts 2 and 1 reports in cycle 17. The bench pulses `start` on a falling edge and counts falling edges from there. It samples `irq`, `err`, `busy` and `dev_id` on the falling edge where each is due, and checks `busy` and `irq` again one falling edge later. Under the stalled-grant pattern the latency varies, so those runs are judged on the memory and device contents and on a latency longer than the no-stall figure.

// File: rtl/cmd_iop_pkg.sv
package cmd_iop_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_FETCH, ST_DECODE, ST_DEV_RD,
      ST_MEM_WR, ST_MEM_RD, ST_DEV_WR, ST_DONE
   } iop_state_e;

   localparam int OP_DEV2MEM = 1;
   localparam int OP_MEM2DEV = 2;
   localparam int CMD_WORDS  = 4;
endpackage

// File: rtl/iop_cmd_decode.sv
module iop_cmd_decode #(
   parameter int OPW      = 4,
   parameter int DEVW     = 4,
   parameter int CNTW     = 16,
   parameter bit CHAIN_EN = 1'b1
) (
   input  logic [OPW+DEVW-1:0] ctl_word,
   input  logic [CNTW-1:0]     cnt_word,
   input  logic                chain_bit,
   output logic                dir_in,
   output logic                op_bad,
   output logic                cnt_none,
   output logic                chain,
   output logic [DEVW-1:0]     dev
);
   import cmd_iop_pkg::*;

   logic [OPW-1:0] op;
   logic           dir_out;

   assign op       = ctl_word[OPW-1:0];
   assign dev      = ctl_word[OPW+DEVW-1:OPW];
   assign dir_in   = (op == OPW'(OP_DEV2MEM));
   assign dir_out  = (op == OPW'(OP_MEM2DEV));
   assign op_bad   = !(dir_in || dir_out);
   assign cnt_none = (cnt_word == '0);

   generate
      if (CHAIN_EN) begin : g_chain
         assign chain = chain_bit;
      end else begin : g_nochain
         assign chain = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/iop_xfer_ctr.sv
module iop_xfer_ctr #(
   parameter int AW   = 16,
   parameter int CNTW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [AW-1:0]   load_addr,
   input  logic [CNTW-1:0] load_cnt,
   input  logic            step,
   output logic [AW-1:0]   addr,
   output logic            cnt_last
);
   logic [CNTW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr   <= '0;
         left_q <= '0;
      end else if (load) begin
         addr   <= load_addr;
         left_q <= load_cnt;
      end else if (step) begin
         addr   <= addr + AW'(1);
         left_q <= left_q - CNTW'(1);
      end
   end

   assign cnt_last = (left_q == CNTW'(1));
endmodule

// File: rtl/iop_ctrl.sv
module iop_ctrl #(
   parameter int AW   = 16,
   parameter int DW   = 32,
   parameter int OPW  = 4,
   parameter int DEVW = 4,
   parameter int CNTW = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [AW-1:0]       cmd_ptr,
   input  logic                mem_gnt,
   input  logic [DW-1:0]       mem_rdata,
   input  logic [DW-1:0]       dev_rdata,
   input  logic                dir_in,
   input  logic                op_bad,
   input  logic                cnt_none,
   input  logic                chain,
   input  logic                cnt_last,
   input  logic [AW-1:0]       xfer_addr,
   output logic [OPW+DEVW-1:0] ctl_word,
   output logic [AW-1:0]       addr_word,
   output logic [CNTW-1:0]     cnt_word,
   output logic                chain_bit,
   output logic                ctr_load,
   output logic                ctr_step,
   output logic                mem_req,
   output logic                mem_we,
   output logic [AW-1:0]       mem_addr,
   output logic [DW-1:0]       mem_wdata,
   output logic                dev_rd,
   output logic                dev_wr,
   output logic [DW-1:0]       dev_wdata,
   output logic                busy,
   output logic                irq,
   output logic                err
);
   import cmd_iop_pkg::*;

   localparam int FIW = $clog2(CMD_WORDS);

   iop_state_e     state_q;
   logic [AW-1:0]  ptr_q;
   logic [FIW-1:0] fidx_q;
   logic [DW-1:0]  hold_q;
   logic           last_fetch;

   assign last_fetch = (fidx_q == FIW'(CMD_WORDS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         ptr_q     <= '0;
         fidx_q    <= '0;
         hold_q    <= '0;
         err       <= 1'b0;
         ctl_word  <= '0;
         addr_word <= '0;
         cnt_word  <= '0;
         chain_bit <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               ptr_q   <= cmd_ptr;
               fidx_q  <= '0;
               err     <= 1'b0;
               state_q <= ST_FETCH;
            end
            ST_FETCH: if (mem_gnt) begin
               case (fidx_q)
                  FIW'(0): ctl_word  <= mem_rdata[OPW+DEVW-1:0];
                  FIW'(1): addr_word <= mem_rdata[AW-1:0];
                  FIW'(2): cnt_word  <= mem_rdata[CNTW-1:0];
                  default: chain_bit <= mem_rdata[0];
               endcase
               fidx_q <= fidx_q + FIW'(1);
               if (last_fetch) state_q <= ST_DECODE;
            end
            ST_DECODE: begin
               if (op_bad) begin
                  err     <= 1'b1;
                  state_q <= ST_DONE;
               end else if (cnt_none) begin
                  if (chain) begin
                     ptr_q   <= ptr_q + AW'(CMD_WORDS);
                     state_q <= ST_FETCH;
                  end else begin
                     state_q <= ST_DONE;
                  end
               end else begin
                  state_q <= dir_in ? ST_DEV_RD : ST_MEM_RD;
               end
            end
            ST_DEV_RD: begin
               hold_q  <= dev_rdata;
               state_q <= ST_MEM_WR;
            end
            ST_MEM_WR: if (mem_gnt) begin
               if (!cnt_last)  state_q <= ST_DEV_RD;
               else if (chain) begin
                  ptr_q   <= ptr_q + AW'(CMD_WORDS);
                  state_q <= ST_FETCH;
               end else state_q <= ST_DONE;
            end
            ST_MEM_RD: if (mem_gnt) begin
               hold_q  <= mem_rdata;
               state_q <= ST_DEV_WR;
            end
            ST_DEV_WR: begin
               if (!cnt_last)  state_q <= ST_MEM_RD;
               else if (chain) begin
                  ptr_q   <= ptr_q + AW'(CMD_WORDS);
                  state_q <= ST_FETCH;
               end else state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ctr_load  = (state_q == ST_DECODE);
   assign ctr_step  = ((state_q == ST_MEM_WR) && mem_gnt) || (state_q == ST_DEV_WR);
   assign mem_req   = (state_q == ST_FETCH) || (state_q == ST_MEM_WR) || (state_q == ST_MEM_RD);
   assign mem_we    = (state_q == ST_MEM_WR);
   assign mem_addr  = (state_q == ST_FETCH) ? ptr_q + AW'(fidx_q) : xfer_addr;
   assign mem_wdata = hold_q;
   assign dev_rd    = (state_q == ST_DEV_RD);
   assign dev_wr    = (state_q == ST_DEV_WR);
   assign dev_wdata = hold_q;
   assign busy      = (state_q != ST_IDLE);
   assign irq       = (state_q == ST_DONE);
endmodule

// File: rtl/cmd_iop.sv
module cmd_iop #(
   parameter int AW       = 16,
   parameter int DW       = 32,
   parameter int OPW      = 4,
   parameter int DEVW     = 4,
   parameter int CNTW     = 16,
   parameter bit CHAIN_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [AW-1:0]   cmd_ptr,
   output logic            busy,
   output logic            irq,
   output logic            err,
   output logic            mem_req,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   input  logic            mem_gnt,
   input  logic [DW-1:0]   mem_rdata,
   output logic [DEVW-1:0] dev_id,
   output logic            dev_rd,
   input  logic [DW-1:0]   dev_rdata,
   output logic            dev_wr,
   output logic [DW-1:0]   dev_wdata
);
   generate
      if (DW < OPW + DEVW) begin : g_bad_ctl
         $error("control word fields exceed DW");
      end
      if (AW > DW || CNTW > DW) begin : g_bad_word
         $error("address or count wider than DW");
      end
   endgenerate

   logic [OPW+DEVW-1:0] ctl_word;
   logic [AW-1:0]       addr_word;
   logic [CNTW-1:0]     cnt_word;
   logic                chain_bit, dir_in, op_bad, cnt_none, chain;
   logic                ctr_load, ctr_step, cnt_last;
   logic [AW-1:0]       xfer_addr;

   iop_cmd_decode #(.OPW(OPW), .DEVW(DEVW), .CNTW(CNTW), .CHAIN_EN(CHAIN_EN)) u_dec (
      .ctl_word(ctl_word), .cnt_word(cnt_word), .chain_bit(chain_bit),
      .dir_in(dir_in), .op_bad(op_bad), .cnt_none(cnt_none),
      .chain(chain), .dev(dev_id)
   );

   iop_xfer_ctr #(.AW(AW), .CNTW(CNTW)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_addr(addr_word),
      .load_cnt(cnt_word), .step(ctr_step), .addr(xfer_addr), .cnt_last(cnt_last)
   );

   iop_ctrl #(.AW(AW), .DW(DW), .OPW(OPW), .DEVW(DEVW), .CNTW(CNTW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_ptr(cmd_ptr),
      .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .dev_rdata(dev_rdata),
      .dir_in(dir_in), .op_bad(op_bad), .cnt_none(cnt_none), .chain(chain),
      .cnt_last(cnt_last), .xfer_addr(xfer_addr),
      .ctl_word(ctl_word), .addr_word(addr_word), .cnt_word(cnt_word),
      .chain_bit(chain_bit), .ctr_load(ctr_load), .ctr_step(ctr_step),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .dev_rd(dev_rd), .dev_wr(dev_wr),
      .dev_wdata(dev_wdata), .busy(busy), .irq(irq), .err(err)
   );
endmodule

// File: rtl/cmd_iop_chk.sv
module cmd_iop_chk #(
   parameter int AW = 16,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          irq,
   input logic          err,
   input logic          mem_req,
   input logic          mem_we,
   input logic          mem_gnt,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata,
   input logic          dev_rd,
   input logic          dev_wr
);
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !dev_rd && !dev_wr));

   // R6
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R6
   wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && !mem_gnt) |=> $stable(mem_wdata));

   // R7
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> (!irq && !busy));

   // R8
   err_at_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> irq);

   // R4
   dev_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_rd && dev_wr) && !(dev_rd && mem_req) && !(dev_wr && mem_req));
endmodule

bind cmd_iop cmd_iop_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq), .err(err),
   .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata),
   .dev_rd(dev_rd), .dev_wr(dev_wr)
);

// File: tb/cmd_iop_tb.sv
module cmd_iop_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] cmd_ptr = '0;
   logic        busy, irq, err, mem_req, mem_we, mem_gnt, dev_rd, dev_wr;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata, dev_rdata, dev_wdata;
   logic [3:0]  dev_id;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   logic [31:0] mem [256];
   logic [31:0] snk [64];
   logic [3:0]  snk_dev [64];
   int          snk_n = 0;
   logic [15:0] src_seq = '0;
   logic [15:0] rd_log [64];
   int          rd_n = 0;
   int          irq_n = 0;
   int          gcnt = 0;
   logic        stall = 1'b0;
   logic        hw_en = 1'b0;
   logic [7:0]  hw_addr = '0;
   logic [31:0] hw_data = '0;

   always #4 clk = ~clk;

   cmd_iop u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_ptr(cmd_ptr),
      .busy(busy), .irq(irq), .err(err),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .dev_id(dev_id), .dev_rd(dev_rd), .dev_rdata(dev_rdata),
      .dev_wr(dev_wr), .dev_wdata(dev_wdata)
   );

   assign mem_gnt   = stall ? ((gcnt % 3) == 2) : 1'b1;
   assign mem_rdata = mem[mem_addr[7:0]];
   assign dev_rdata = {4'hA, 8'h00, dev_id, src_seq};

   always @(posedge clk) begin
      cyc  <= cyc + 1;
      gcnt <= gcnt + 1;
      if (hw_en) mem[hw_addr] <= hw_data;
      if (mem_req && mem_gnt && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_req && mem_gnt && !mem_we && rd_n < 64) begin
         rd_log[rd_n] <= mem_addr;
         rd_n <= rd_n + 1;
      end
      if (dev_rd) src_seq <= src_seq + 16'd1;
      if (dev_wr && snk_n < 64) begin
         snk[snk_n]     <= dev_wdata;
         snk_dev[snk_n] <= dev_id;
         snk_n <= snk_n + 1;
      end
      if (irq) irq_n <= irq_n + 1;
   end

   always @(negedge clk) begin
      if (cyc > 100000) begin
         errors = errors + 1;
         $display("FAIL watchdog actual=%0d expected=<100000", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic poke(input logic [7:0] a, input logic [31:0] d);
      hw_en = 1'b1; hw_addr = a; hw_data = d;
      @(negedge clk);
      hw_en = 1'b0;
   endtask

   task automatic put_cmd(input logic [7:0] base, input logic [3:0] op, input logic [3:0] dev,
                          input logic [15:0] addr, input logic [15:0] cnt, input logic chn);
      poke(base,        {24'h0, dev, op});
      poke(base + 8'd1, {16'h0, addr});
      poke(base + 8'd2, {16'h0, cnt});
      poke(base + 8'd3, {31'h0, chn});
   endtask

   function automatic logic [31:0] src_word(input logic [3:0] dev, input logic [15:0] seq);
      return {4'hA, 8'h00, dev, seq};
   endfunction

   int          lat;
   logic        err_at;
   logic [3:0]  dev_at;

   // k counts clock edges from the start edge (that edge is 1)
   task automatic wait_irq();
      int k = 1;
      while (!irq && k < 500) begin
         @(negedge clk);
         k++;
      end
      lat = k; err_at = err; dev_at = dev_id;
      @(negedge clk);
      chk("R7 irq single cycle", {31'h0, irq}, 32'h0);
      chk("R7 busy drops after irq", {31'h0, busy}, 32'h0);
   endtask

   task automatic launch(input logic [15:0] p);
      start = 1'b1; cmd_ptr = p;
      @(negedge clk);
      start = 1'b0;
      wait_irq();
   endtask

   task automatic t_reset();
      chk("R1 busy", {31'h0, busy}, 32'h0);
      chk("R1 irq", {31'h0, irq}, 32'h0);
      chk("R1 err", {31'h0, err}, 32'h0);
      chk("R1 quiet", {29'h0, mem_req, dev_rd, dev_wr}, 32'h0);
   endtask

   task automatic t_dev2mem();
      logic [15:0] s0;
      int r0;
      put_cmd(8'h10, 4'd1, 4'd3, 16'h0040, 16'd3, 1'b0);
      poke(8'h43, 32'hCAFE_0043);
      s0 = src_seq; r0 = rd_n;
      launch(16'h0010);
      chk("R7 latency N=3", 32'(lat), 32'd12);
      chk("R3 dev_id", {28'h0, dev_at}, 32'h3);
      for (int i = 0; i < 4; i++) chk("R2 fetch order", {16'h0, rd_log[r0 + i]}, 32'h10 + 32'(i));
      for (int i = 0; i < 3; i++) chk("R4 word", mem[8'h40 + 8'(i)], src_word(4'd3, s0 + 16'(i)));
      chk("R4 no overrun", mem[8'h43], 32'hCAFE_0043);
      chk("R4 err clear", {31'h0, err_at}, 32'h0);
   endtask

   task automatic t_mem2dev();
      int n0;
      put_cmd(8'h20, 4'd2, 4'd5, 16'h0060, 16'd2, 1'b0);
      poke(8'h60, 32'h1111_0001);
      poke(8'h61, 32'h2222_0002);
      n0 = snk_n;
      launch(16'h0020);
      chk("R7 latency N=2", 32'(lat), 32'd10);
      chk("R5 word count", 32'(snk_n - n0), 32'd2);
      chk("R5 word0", snk[n0], 32'h1111_0001);
      chk("R5 word1", snk[n0 + 1], 32'h2222_0002);
      chk("R3 dev on write", {28'h0, snk_dev[n0]}, 32'h5);
   endtask

   task automatic t_bad_op();
      logic [15:0] s0;
      int n0;
      put_cmd(8'h30, 4'd7, 4'd1, 16'h0048, 16'd2, 1'b0);
      poke(8'h48, 32'hDEAD_BEEF);
      s0 = src_seq; n0 = snk_n;
      launch(16'h0030);
      chk("R8 latency", 32'(lat), 32'd6);
      chk("R8 err at irq", {31'h0, err_at}, 32'h1);
      chk("R12 err held", {31'h0, err}, 32'h1);
      chk("R8 no dev read", {16'h0, src_seq}, {16'h0, s0});
      chk("R8 no dev write", 32'(snk_n), 32'(n0));
      chk("R8 no mem write", mem[8'h48], 32'hDEAD_BEEF);
   endtask

   task automatic t_zero_cnt();
      logic [15:0] s0;
      put_cmd(8'h38, 4'd1, 4'd2, 16'h004C, 16'd0, 1'b0);
      poke(8'h4C, 32'h0BAD_F00D);
      s0 = src_seq;
      launch(16'h0038);
      chk("R9 latency", 32'(lat), 32'd6);
      chk("R12 err cleared by start", {31'h0, err_at}, 32'h0);
      chk("R9 no dev read", {16'h0, src_seq}, {16'h0, s0});
      chk("R9 no mem write", mem[8'h4C], 32'h0BAD_F00D);
   endtask

   task automatic t_stall();
      logic [15:0] s0;
      put_cmd(8'h90, 4'd1, 4'd4, 16'h0050, 16'd4, 1'b0);
      poke(8'h54, 32'h5454_5454);
      s0 = src_seq;
      stall = 1'b1;
      launch(16'h0090);
      stall = 1'b0;
      chk("R6 stalled run longer", {31'h0, (lat > 14)}, 32'h1);
      for (int i = 0; i < 4; i++) chk("R6 word under stall", mem[8'h50 + 8'(i)], src_word(4'd4, s0 + 16'(i)));
      chk("R6 no overrun", mem[8'h54], 32'h5454_5454);
   endtask

   task automatic t_chain();
      logic [15:0] s0;
      int n0, q0;
      put_cmd(8'h80, 4'd1, 4'd2, 16'h0070, 16'd2, 1'b1);
      put_cmd(8'h84, 4'd2, 4'd6, 16'h0058, 16'd1, 1'b0);
      poke(8'h58, 32'h5858_5858);
      s0 = src_seq; n0 = snk_n; q0 = irq_n;
      launch(16'h0080);
      repeat (3) @(negedge clk);
      chk("R10 latency of chain", 32'(lat), 32'd17);
      chk("R10 one irq", 32'(irq_n - q0), 32'd1);
      chk("R10 first cmd w0", mem[8'h70], src_word(4'd2, s0));
      chk("R10 first cmd w1", mem[8'h71], src_word(4'd2, s0 + 16'd1));
      chk("R10 second cmd", snk[n0], 32'h5858_5858);
      chk("R10 second dev", {28'h0, snk_dev[n0]}, 32'h6);
   endtask

   task automatic t_start_busy();
      logic [15:0] s0;
      int q0;
      s0 = src_seq; q0 = irq_n;
      start = 1'b1; cmd_ptr = 16'h0010;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      start = 1'b1; cmd_ptr = 16'h0030;
      @(negedge clk);
      start = 1'b0;
      // two edges already passed since start, so resume counting at 3
      begin
         int k = 3;
         while (!irq && k < 500) begin
            @(negedge clk);
            k++;
         end
         lat = k; err_at = err;
      end
      repeat (10) @(negedge clk);
      chk("R11 latency unchanged", 32'(lat), 32'd12);
      chk("R11 no err", {31'h0, err_at}, 32'h0);
      chk("R11 one irq", 32'(irq_n - q0), 32'd1);
      chk("R11 busy idle", {31'h0, busy}, 32'h0);
      for (int i = 0; i < 3; i++) chk("R11 data", mem[8'h40 + 8'(i)], src_word(4'd3, s0 + 16'(i)));
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_dev2mem();
      t_mem2dev();
      t_bad_op();
      t_zero_cnt();
      t_stall();
      t_chain();
      t_start_busy();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule